// File: doc/BRIEF.md
# Auto-Reloading Countdown Timer with Level or Pulse Interrupt

An 8-bit down counter paced by one of four ticks: the 4.096 kHz base strobe, or the 64 Hz, 1 Hz and one-per-minute ticks that an internal divider chain derives from it. Software programs a reload count and a mode word through a small register port. Each time the count runs out, the block sets a sticky flag, reloads the count and begins the next period without software action.

The interrupt line is active low and works in one of two styles. In level style it stays low for as long as the flag is set and the interrupt is enabled. In pulse style it gives one short low pulse per period, and the flag has no effect on it. A reload count of zero parks the timer: no ticks are consumed and the flag never rises.

Register map, selected by a 2-bit address. Address 0 is the count: a write loads both the reload value and the live counter, and a read returns the live counter. Address 1 is the mode: bits [4:3] tick select, bit 2 run enable, bit 1 interrupt enable, bit 0 pulse style. Address 2 is the status: bit 0 is the flag. Address 3 reads zero and ignores writes.

Top module: `cdt_timer`

## Requirements
- R1: After reset the mode register reads 18h, the count register reads 00h, the status register reads 00h and `irq_n` is high.
- R2: Tick select 00 counts on every base tick, 01 on every DIV_64-th base tick, 10 on every DIV_64*DIV_1HZ-th, and 11 on every DIV_64*DIV_1HZ*DIV_MIN-th. One period lasts the reload count multiplied by the selected tick interval.
- R3: When a selected tick arrives while the counter holds 1, the flag is set and the counter takes the reload value on the same edge, so successive periods have equal length.
- R4: With a reload count of 0 the timer consumes no ticks and never sets the flag.
- R5: The flag stays set until software writes status bit 0 as 0. Writing 1 to that bit, or disabling the timer, leaves it set.
- R6: With pulse style 0 and interrupt enable 1, `irq_n` is low exactly while the flag is set.
- R7: With pulse style 1 and interrupt enable 1, `irq_n` goes low once per period whatever the flag state. The low phase lasts one base-tick interval under tick select 00, and one 64 Hz tick interval under any other select.
- R8: With interrupt enable 0, `irq_n` stays high, and the flag is still set at the end of every period.
- R9: While run enable is 0 the counter holds the reload value, and a read of address 0 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| base_tick | input | 1 | One-cycle strobe at the 4.096 kHz base rate |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| irq_n | output | 1 | Interrupt output, active low |

## Verification
A corrupted divider phase or counter value shows up at `irq_n` as a changed gap between consecutive interrupt pulses. That change is visible within the second period after enable, and the bench measures that gap in base ticks for each tick select. A flag that is lost or set spuriously shows at the level-style output on the very next cycle, and at the status read. A pulse register that is left set, or cleared too soon, changes the measured low width of the first pulse.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
    localparam int unsigned CNT_W  = 8;
    localparam int unsigned ADDR_W = 2;

    localparam logic [ADDR_W-1:0] A_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] A_MODE  = 2'd1;
    localparam logic [ADDR_W-1:0] A_STAT  = 2'd2;

    typedef enum logic [1:0] {
        TS_BASE = 2'b00,
        TS_64   = 2'b01,
        TS_1    = 2'b10,
        TS_MIN  = 2'b11
    } tick_sel_e;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] reload;
        tick_sel_e        sel;
        logic             te;
        logic             tie;
        logic             tp;
        logic             flag;
    } tmr_state_t;
endpackage

// File: rtl/cdt_div_stage.sv
module cdt_div_stage #(
    parameter int unsigned DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_out
);
    localparam int unsigned CW = (DIV > 2) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d    = cnt_q;
        tick_out = tick_in && (cnt_q == LAST);
        if (tick_in) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/cdt_irq_gen.sv
module cdt_irq_gen (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_base,
    input  logic tick_64,
    input  logic fast_sel,
    input  logic fire,
    input  logic flag,
    input  logic tie,
    input  logic tp,
    output logic irq_n
);
    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = pulse_q;
        if (fire && tp) begin
            pulse_d = 1'b1;
        end else if (fast_sel ? tick_base : tick_64) begin
            pulse_d = 1'b0;
        end
        irq_n = !(tie && (tp ? pulse_q : flag));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= pulse_d;
    end
endmodule

// File: rtl/cdt_timer.sv
module cdt_timer #(
    parameter int unsigned DIV_64  = 64,
    parameter int unsigned DIV_1HZ = 64,
    parameter int unsigned DIV_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       base_tick,
    input  logic       wr_en,
    input  logic [1:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       irq_n
);
    import cdt_pkg::*;

    localparam int unsigned N_STAGE = 3;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [N_STAGE:0] chain;
    tmr_state_t       st_d, st_q;
    logic             tick_sel;
    logic             fire;

    assign chain[0] = base_tick;

    for (genvar g = 0; g < N_STAGE; g++) begin : g_div
        localparam int unsigned SDIV = (g == 0) ? DIV_64 : (g == 1) ? DIV_1HZ : DIV_MIN;
        cdt_div_stage #(.DIV(SDIV)) u_stage (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_in (chain[g]),
            .tick_out(chain[g+1])
        );
    end

    always_comb begin
        st_d = st_q;
        case (st_q.sel)
            TS_BASE: tick_sel = chain[0];
            TS_64:   tick_sel = chain[1];
            TS_1:    tick_sel = chain[2];
            default: tick_sel = chain[3];
        endcase
        fire = tick_sel && st_q.te && (st_q.reload != '0) && (st_q.cnt <= ONE);

        if (!st_q.te) begin
            st_d.cnt = st_q.reload;
        end else if (tick_sel && (st_q.reload != '0)) begin
            st_d.cnt = (st_q.cnt <= ONE) ? st_q.reload : st_q.cnt - ONE;
        end
        if (fire) begin
            st_d.flag = 1'b1;
        end

        if (wr_en) begin
            case (wr_addr)
                A_COUNT: begin
                    st_d.reload = wr_data[CNT_W-1:0];
                    st_d.cnt    = wr_data[CNT_W-1:0];
                end
                A_MODE: begin
                    st_d.sel = tick_sel_e'(wr_data[4:3]);
                    st_d.te  = wr_data[2];
                    st_d.tie = wr_data[1];
                    st_d.tp  = wr_data[0];
                end
                A_STAT: begin
                    if (!wr_data[0] && !fire) st_d.flag = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, reload: '0, sel: TS_MIN, te: 1'b0, tie: 1'b0, tp: 1'b0, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (rd_addr)
            A_COUNT: rd_data = st_q.cnt;
            A_MODE:  rd_data = {3'b000, st_q.sel, st_q.te, st_q.tie, st_q.tp};
            A_STAT:  rd_data = {7'b0000000, st_q.flag};
            default: rd_data = '0;
        endcase
    end

    cdt_irq_gen u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_base(chain[0]),
        .tick_64  (chain[1]),
        .fast_sel (st_q.sel == TS_BASE),
        .fire     (fire),
        .flag     (st_q.flag),
        .tie      (st_q.tie),
        .tp       (st_q.tp),
        .irq_n    (irq_n)
    );
endmodule

// File: rtl/cdt_timer_chk.sv
module cdt_timer_chk (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [1:0]          wr_addr,
    input logic [7:0]          wr_data,
    input logic                fire,
    input logic                irq_n,
    input cdt_pkg::tmr_state_t st_q
);
    import cdt_pkg::*;

    AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.flag && !(wr_en && wr_addr == A_STAT && !wr_data[0])) |=> st_q.flag); // R5

    AST_LEVEL_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.tp && st_q.tie && st_q.flag) |-> !irq_n); // R6

    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.tie |-> irq_n); // R8

    AST_PULSE_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && st_q.tp && st_q.tie && !(wr_en && wr_addr == A_MODE)) |=> !irq_n); // R7

    AST_RELOAD_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_en) |=> (st_q.flag && st_q.cnt == $past(st_q.reload))); // R3

    AST_ZERO_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.reload == '0 && !wr_en) |=> !$rose(st_q.flag)); // R4
endmodule

bind cdt_timer cdt_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .fire   (fire),
    .irq_n  (irq_n),
    .st_q   (st_q)
);

// File: tb/cdt_timer_test.sv
module cdt_timer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       base_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       irq_n;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    cdt_timer #(.DIV_64(4), .DIV_1HZ(4), .DIV_MIN(3)) uut (
        .clk(clk), .rst_n(rst_n), .base_tick(base_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .irq_n(irq_n)
    );

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  val;
        logic [15:0] ticks;
        logic [7:0]  low;
    } vec_t;

    // base ticks per period = val * (1, 4, 16, 48); low width in clocks = 4 or 16
    localparam vec_t VECS [7] = '{
        '{sel: 2'd0, val: 8'd5,   ticks: 16'd5,   low: 8'd4},
        '{sel: 2'd0, val: 8'd2,   ticks: 16'd2,   low: 8'd4},
        '{sel: 2'd1, val: 8'd3,   ticks: 16'd12,  low: 8'd16},
        '{sel: 2'd1, val: 8'd2,   ticks: 16'd8,   low: 8'd16},
        '{sel: 2'd2, val: 8'd2,   ticks: 16'd32,  low: 8'd16},
        '{sel: 2'd3, val: 8'd1,   ticks: 16'd48,  low: 8'd16},
        '{sel: 2'd0, val: 8'd255, ticks: 16'd255, low: 8'd4}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        rd_addr = a;
        @(negedge clk);
        d = rd_data;
    endtask

    task automatic wait_low(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            if (irq_n == 1'b0) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    initial begin
        wait (rst_n);
        forever begin
            repeat (3) @(posedge clk);
            #1 base_tick = 1'b1;
            @(posedge clk);
            #1 base_tick = 1'b0;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL WDOG run hung actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        bit seen;
        int lowc, ticks, guard;

        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        chk(irq_n == 1'b1, "R1 irq_n", irq_n, 1);
        rd(2'd1, d); chk(d == 8'h18, "R1 mode", d, 8'h18);
        rd(2'd0, d); chk(d == 8'h00, "R1 count", d, 0);
        rd(2'd2, d); chk(d == 8'h00, "R1 status", d, 0);

        // R9 counter held while disabled
        wr(2'd0, 8'd9);
        repeat (50) @(posedge clk);
        rd(2'd0, d); chk(d == 8'd9, "R9 held count", d, 9);

        // Vector table: pulse style, period and pulse width (R2 R3 R7)
        foreach (VECS[k]) begin
            wr(2'd1, {3'b000, VECS[k].sel, 3'b000});
            repeat (40) @(posedge clk);
            wr(2'd0, VECS[k].val);
            wr(2'd2, 8'h00);
            wr(2'd1, {3'b000, VECS[k].sel, 3'b111});
            wait_low(seen);
            chk(seen, "R7 first pulse", seen, 1);
            lowc = 0; ticks = 0; guard = 0;
            while (irq_n == 1'b0 && guard < 5000) begin
                lowc++; guard++;
                if (base_tick) ticks++;
                @(negedge clk);
            end
            while (irq_n == 1'b1 && guard < 5000) begin
                guard++;
                if (base_tick) ticks++;
                @(negedge clk);
            end
            chk(lowc == int'(VECS[k].low), "R7 pulse width", lowc, VECS[k].low);
            chk(ticks == int'(VECS[k].ticks), "R2 R3 period ticks", ticks, VECS[k].ticks);
            rd(2'd2, d);
            chk(d == 8'h01, "R7 flag set but irrelevant", d, 1);
        end

        // R6 level style and R5 sticky flag
        wr(2'd1, 8'b000_00_010);
        repeat (40) @(posedge clk);
        wr(2'd0, 8'd3);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk(irq_n == 1'b1, "R6 high with flag clear", irq_n, 1);
        wr(2'd1, 8'b000_00_110);
        wait_low(seen);
        chk(seen, "R6 level asserted", seen, 1);
        lowc = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (irq_n == 1'b0) lowc++;
        end
        chk(lowc == 40, "R6 level holds", lowc, 40);
        wr(2'd1, 8'b000_00_010);
        @(negedge clk);
        chk(irq_n == 1'b0, "R5 kept after disable", irq_n, 0);
        wr(2'd2, 8'h01);
        @(negedge clk);
        chk(irq_n == 1'b0, "R5 write one ignored", irq_n, 0);
        wr(2'd2, 8'h00);
        @(negedge clk);
        chk(irq_n == 1'b1, "R5 cleared by zero", irq_n, 1);
        rd(2'd2, d); chk(d == 8'h00, "R5 status after clear", d, 0);

        // R8 interrupt disabled
        wr(2'd0, 8'd2);
        wr(2'd1, 8'b000_00_100);
        lowc = 0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (irq_n == 1'b0) lowc++;
        end
        chk(lowc == 0, "R8 irq stays high", lowc, 0);
        rd(2'd2, d); chk(d == 8'h01, "R8 flag still sets", d, 1);

        // R4 zero count halts
        wr(2'd1, 8'b000_00_000);
        wr(2'd0, 8'd0);
        wr(2'd2, 8'h00);
        wr(2'd1, 8'b000_00_110);
        lowc = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (irq_n == 1'b0) lowc++;
        end
        chk(lowc == 0, "R4 no interrupt", lowc, 0);
        rd(2'd2, d); chk(d == 8'h00, "R4 flag stays clear", d, 0);
        rd(2'd0, d); chk(d == 8'h00, "R4 count stays zero", d, 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule